// File: doc/BRIEF.md
# Back-Pressured Command Queue

This block is the device-side receiver for command words arriving over a simple memory-mapped bus. The host writes a command word to the command address, and the word goes into an internal queue. A consumer behind the block drains the queue one word at a time through a valid/ready pop port. The host can read a status word at any time. The low bits of that word hold the number of free queue slots.

A command write that arrives while the queue is full is never refused or dropped. Instead, the block keeps its ready output low, so the bus transaction stretches until the consumer removes a word. The held write then completes.

Because a host can only see the free count from a status read, and free space only grows between reads, a driver can safely write up to the last count it read before it needs to read the status again.

Top module: `stall_cmd_fifo`

## Requirements
- R1: After a synchronous active-high reset, the queue is empty. `cmd_valid` is low, and a status read reports a free count equal to DEPTH.
- R2: A write to word address 0 while the queue is not full completes in the same cycle with `bus_ready` high. Words leave on `cmd_data` in the order they were written.
- R3: A read at word address 1 completes in the same cycle with `bus_ready` high. `bus_rdata` bits [CW-1:0] (CW = clog2(DEPTH+1)) hold DEPTH minus the current occupancy, and all higher bits are zero.
- R4: A write to address 0 while the queue is full keeps `bus_ready` low for as long as no pop occurs. While held, it neither changes the occupancy nor disturbs the stored words.
- R5: If a held write and a pop happen in the same cycle, the write is accepted in that cycle, with `bus_ready` high and the word stored.
- R6: `cmd_valid` is high exactly when the queue holds a word. A pop happens when `cmd_valid` and `cmd_ready` are both high, and it removes one word. Asserting `cmd_ready` while the queue is empty has no effect.
- R7: A write to address 1 completes with `bus_ready` high and stores nothing. A read at any address other than 1 returns zero.
- R8: When a write and a pop happen in the same cycle while the queue is neither full nor empty, the occupancy stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus transaction request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word address (0 = command, 1 = status) |
| bus_wdata | input | DW | Write data (command word) |
| bus_ready | output | 1 | Transaction completes this cycle |
| bus_rdata | output | DW | Read data, valid while `bus_ready` is high on a read |
| cmd_valid | output | 1 | Queue head is available |
| cmd_data | output | DW | Queue head word |
| cmd_ready | input | 1 | Consumer takes the head word |

## Verification
The bench uses a four-entry queue and steps it through every occupancy from empty to full. At each step it checks the reported free count against a count it keeps itself. A design with an off-by-one full test would either overwrite the oldest word or stall one slot early, and either fault shows up in the count or in the drain order.

The bench then holds a write against a full queue for several cycles and releases it with a pop in the same cycle. A design that dropped the held word, overwrote a stored word, or needed an extra cycle before accepting would lose a word or reorder the drained stream.

Finally, the bench covers status writes, reads of unused addresses, pops on an empty queue, and a simultaneous write and pop in mid-range. Faulty decoding or count arithmetic would show up as a stored word or a wrong free count.

// File: rtl/scf_pkg.sv
package scf_pkg;
  // Word addresses on the device bus
  localparam int unsigned ADDR_CMD  = 0;
  localparam int unsigned ADDR_STAT = 1;
endpackage

// File: rtl/scf_store.sv
module scf_store #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          full,
  output logic [CW-1:0] free
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic [CW-1:0] free_r;

  // Storage array: no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end
  assign out_data = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      count  <= '0;
      free_r <= CW'(DEPTH);
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      if (push && !pop) begin
        count  <= count + CW'(1);
        free_r <= free_r - CW'(1);
      end else if (pop && !push) begin
        count  <= count - CW'(1);
        free_r <= free_r + CW'(1);
      end
    end
  end

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign free      = free_r;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |-> !push);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full);
  // R3
  free_sum_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, free_r} + {1'b0, count}) == (CW + 1)'(DEPTH));
  // R6
  drain_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> count == $past(count) - CW'(1));
  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !pop);
endmodule

// File: rtl/scf_bus.sv
module scf_bus
  import scf_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          full,
  input  logic          pop,
  input  logic [CW-1:0] free,
  output logic          ready,
  output logic          push,
  output logic [DW-1:0] push_data,
  output logic [DW-1:0] rdata
);
  logic at_cmd, at_stat, wr_cmd, rd_stat;

  assign at_cmd  = (addr == AW'(ADDR_CMD));
  assign at_stat = (addr == AW'(ADDR_STAT));
  assign wr_cmd  = req && we && at_cmd;
  assign rd_stat = req && !we && at_stat;

  // A command write waits only while full and nothing drains this cycle
  assign push      = wr_cmd && (!full || pop);
  assign push_data = wdata;
  assign ready     = req && (!wr_cmd || !full || pop);
  assign rdata     = rd_stat ? DW'(free) : '0;

  // R4
  full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && full && !pop) |-> !ready);
  // R5
  pop_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && pop) |-> (push && ready));
  // R7
  stat_write_chk: assert property (@(posedge clk) disable iff (rst)
    (req && we && at_stat) |-> (ready && !push));
  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (push) |-> ready);
endmodule

// File: rtl/stall_cmd_fifo.sv
module stall_cmd_fifo #(
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_ready,
  output logic [DW-1:0] bus_rdata,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_data,
  input  logic          cmd_ready
);
  logic          push, pop, full;
  logic [DW-1:0] push_data;
  logic [CW-1:0] free;

  assign pop = cmd_valid && cmd_ready;

  scf_bus #(.AW(AW), .DW(DW), .CW(CW)) u_bus (
    .clk(clk), .rst(rst),
    .req(bus_req), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .full(full), .pop(pop), .free(free),
    .ready(bus_ready), .push(push), .push_data(push_data), .rdata(bus_rdata)
  );

  scf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .push(push), .push_data(push_data), .pop(pop),
    .out_valid(cmd_valid), .out_data(cmd_data),
    .full(full), .free(free)
  );

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    rst |=> !cmd_valid);
endmodule

// File: tb/stall_cmd_fifo_bench.sv
module stall_cmd_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 4;

  logic          clk = 0;
  logic          rst = 1;
  logic          bus_req = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_ready;
  logic [DW-1:0] bus_rdata;
  logic          cmd_valid;
  logic [DW-1:0] cmd_data;
  logic          cmd_ready = 0;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  stall_cmd_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_stall_cmd_fifo (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // Status read: completes in the driven cycle
  task automatic read_status(input string tag);
    bus_req = 1; bus_we = 0; bus_addr = AW'(1);
    #1;
    check({tag, " status ready"}, int'(bus_ready), 1);
    check({tag, " free count"}, int'(bus_rdata), DEPTH - model_q.size());
    @(negedge clk);
    bus_req = 0;
  endtask

  // Command write expected to complete at once
  task automatic write_cmd(input logic [DW-1:0] d);
    bus_req = 1; bus_we = 1; bus_addr = AW'(0); bus_wdata = d;
    #1;
    check("R2 write ready", int'(bus_ready), 1);
    @(negedge clk);
    bus_req = 0;
    model_q.push_back(d);
  endtask

  task automatic pop_cmd();
    logic [DW-1:0] e;
    cmd_ready = 1;
    #1;
    check("R6 valid before pop", int'(cmd_valid), 1);
    e = model_q.pop_front();
    check("R2 order", int'(cmd_data), int'(e));
    @(negedge clk);
    cmd_ready = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1
    check("R1 valid after reset", int'(cmd_valid), 0);
    @(negedge clk);
    read_status("R1");

    // R3 sweep over every occupancy while filling
    for (int k = 0; k < DEPTH; k++) begin
      write_cmd(DW'(16'h100 + k));
      check("R6 valid when nonempty", int'(cmd_valid), 1);
      read_status("R3 fill");
    end

    // R4 held write against a full queue
    bus_req = 1; bus_we = 1; bus_addr = AW'(0); bus_wdata = 16'hBEEF;
    for (int c = 0; c < 3; c++) begin
      #1;
      check("R4 stall ready low", int'(bus_ready), 0);
      check("R4 head untouched", int'(cmd_data), int'(model_q[0]));
      @(negedge clk);
    end
    // R5 pop in the same cycle releases the held write
    cmd_ready = 1;
    #1;
    check("R5 ready with pop", int'(bus_ready), 1);
    check("R5 head at release", int'(cmd_data), int'(model_q[0]));
    @(negedge clk);
    bus_req = 0; cmd_ready = 0;
    void'(model_q.pop_front());
    model_q.push_back(16'hBEEF);
    read_status("R5 still full");

    // Drain everything in order
    for (int k = 0; k < DEPTH; k++) begin
      pop_cmd();
      read_status("R3 drain");
    end
    #1;
    check("R6 valid when empty", int'(cmd_valid), 0);

    // R6 pop on empty has no effect
    cmd_ready = 1;
    @(negedge clk);
    cmd_ready = 0;
    read_status("R6 empty pop");

    // R7 status write stores nothing
    bus_req = 1; bus_we = 1; bus_addr = AW'(1); bus_wdata = 16'h5A5A;
    #1;
    check("R7 status write ready", int'(bus_ready), 1);
    @(negedge clk);
    bus_req = 0;
    #1;
    check("R7 nothing stored", int'(cmd_valid), 0);
    read_status("R7 after status write");
    // R7 read of unused addresses returns zero
    for (int a = 2; a < 6; a++) begin
      bus_req = 1; bus_we = 0; bus_addr = AW'(a);
      #1;
      check("R7 other address zero", int'(bus_rdata), 0);
      @(negedge clk);
    end
    // R7 read at command address also zero
    bus_addr = AW'(0);
    #1;
    check("R7 cmd address read zero", int'(bus_rdata), 0);
    @(negedge clk);
    bus_req = 0;

    // R8 simultaneous write and pop mid-range
    write_cmd(16'h0A01);
    write_cmd(16'h0A02);
    bus_req = 1; bus_we = 1; bus_addr = AW'(0); bus_wdata = 16'h0A03;
    cmd_ready = 1;
    #1;
    check("R8 write ready", int'(bus_ready), 1);
    check("R8 head", int'(cmd_data), 16'h0A01);
    @(negedge clk);
    bus_req = 0; cmd_ready = 0;
    void'(model_q.pop_front());
    model_q.push_back(16'h0A03);
    read_status("R8 occupancy kept");
    while (model_q.size() > 0) pop_cmd();
    read_status("R8 drained");

    // R1 reset from a nonempty queue
    write_cmd(16'h0C0C);
    rst = 1;
    @(negedge clk);
    rst = 0;
    model_q.delete();
    #1;
    check("R1 valid after second reset", int'(cmd_valid), 0);
    @(negedge clk);
    read_status("R1 second reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule